// File: doc/BRIEF.md
# Floating-point control and status register pair

This block holds the two software-visible registers of a floating-point unit. The control register sets the rounding mode and the two exception enables that the arithmetic datapath reads. The status register collects five sticky exception flags that the floating-point unit reports after each operation. Software reaches both registers over a simple auxiliary-register bus made of an address, write data, a write strobe, a read strobe and read data.

Software cannot simply overwrite the status flags. A status write changes them only when bit 31 of that same write data is set. Bit 31 is a one-shot permission and is never stored. Without it, a status write is dropped and the flags move only as operation side effects. Each time the unit reports an operation, its flags are ORed into the status register. If the operation raised invalid or divide-by-zero and the matching enable is set, the block also pulses a trap request for one cycle.

Top module: `fp_csr`

## Requirements
- R1: After reset the control register reads 0x00000100 (round to nearest, both enables off) and the status register reads 0x00000000.
- R2: A write to address 0x300 loads control bits 0 (invalid enable), 1 (divide-by-zero enable) and 9:8 (rounding mode). All other control bits ignore the write and read as zero.
- R3: `rnd_mode_o` always equals control bits 9:8, coded 00 toward zero, 01 nearest, 10 toward plus infinity and 11 toward minus infinity. `inv_en_o` equals control bit 0 and `dz_en_o` equals control bit 1.
- R4: A write to address 0x301 with data bit 31 set loads the flags from data bits 4:0: invalid at bit 0, divide-by-zero at 1, overflow at 2, underflow at 3, inexact at 4. This is the only way flags can be cleared.
- R5: A write to address 0x301 with data bit 31 clear leaves the flags unchanged.
- R6: Status bit 31 and status bits 30:5 always read as zero.
- R7: In a cycle where `op_vld_i` is high, each bit of `op_flags_i` (same bit order as R4) is ORed into the status flags. When `op_vld_i` is low, `op_flags_i` has no effect.
- R8: If a status write with bit 31 set and an operation report arrive in the same cycle, the flags take the written value alone.
- R9: `trap_req_o` is high for exactly the one cycle after an operation report that raised invalid (flag bit 0) while the invalid enable was set, or raised divide-by-zero (flag bit 1) while the divide-by-zero enable was set. Otherwise it is low.
- R10: `aux_rdata_o` is zero when `aux_re_i` is low and when the read address is neither 0x300 nor 0x301. Otherwise it shows the addressed register in the same cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| aux_addr_i | input | 12 | Auxiliary register address |
| aux_wdata_i | input | 32 | Write data |
| aux_we_i | input | 1 | Write strobe |
| aux_re_i | input | 1 | Read strobe |
| aux_rdata_o | output | 32 | Read data, combinational |
| op_vld_i | input | 1 | Operation flag report valid |
| op_flags_i | input | 5 | Flags raised by the reported operation |
| rnd_mode_o | output | 2 | Rounding mode to the datapath |
| inv_en_o | output | 1 | Invalid-operation trap enable |
| dz_en_o | output | 1 | Divide-by-zero trap enable |
| trap_req_o | output | 1 | One-cycle trap request |

## Verification
The hardest case to reach is a status write with bit 31 set that lands in the same cycle as an operation report carrying flags the write does not hold. The stimulus lines up both strobes on one edge on purpose, with disjoint flag patterns, so the two possible winners give different read values. A second delicate case is a trap raised in the cycle that also rewrites the enables. The trap must follow the old enables, and a random phase mixes control writes with operation reports so this case comes up often.

// File: rtl/fp_csr_pkg.sv
package fp_csr_pkg;
  localparam int AUX_AW  = 12;
  localparam int AUX_DW  = 32;
  localparam int N_FLAGS = 5;

  localparam logic [AUX_AW-1:0] CTRL_ADDR = 12'h300;
  localparam logic [AUX_AW-1:0] STAT_ADDR = 12'h301;

  localparam int IV_EN_BIT = 0;
  localparam int DZ_EN_BIT = 1;
  localparam int RND_LSB   = 8;
  localparam int FWE_BIT   = 31;

  localparam int FLG_IV = 0;
  localparam int FLG_DZ = 1;
  localparam int FLG_OV = 2;
  localparam int FLG_UV = 3;
  localparam int FLG_IX = 4;

  typedef enum logic [1:0] {
    RND_ZERO = 2'b00,
    RND_NEAR = 2'b01,
    RND_PINF = 2'b10,
    RND_NINF = 2'b11
  } rnd_mode_e;

  typedef struct packed {
    rnd_mode_e rnd;
    logic      dz_en;
    logic      iv_en;
  } ctrl_t;

  localparam ctrl_t CTRL_RST = '{rnd: RND_NEAR, dz_en: 1'b0, iv_en: 1'b0};
endpackage

// File: rtl/fp_csr_ctrl.sv
module fp_csr_ctrl
  import fp_csr_pkg::*;
#(
  parameter int DW = AUX_DW
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  output ctrl_t         ctrl_o
);
  ctrl_t ctrl_q;
  ctrl_t ctrl_d;

  always_comb begin
    ctrl_d       = ctrl_q;
    ctrl_d.iv_en = wdata_i[IV_EN_BIT];
    ctrl_d.dz_en = wdata_i[DZ_EN_BIT];
    ctrl_d.rnd   = rnd_mode_e'(wdata_i[RND_LSB+:2]);
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)   ctrl_q <= CTRL_RST;
    else if (wr_i) ctrl_q <= ctrl_d;
  end

  logic unused_wbits;
  assign unused_wbits = ^{wdata_i[DW-1:RND_LSB+2], wdata_i[RND_LSB-1:DZ_EN_BIT+1]};

  assign ctrl_o = ctrl_q;
endmodule

// File: rtl/fp_csr_flags.sv
module fp_csr_flags
  import fp_csr_pkg::*;
#(
  parameter int DW = AUX_DW,
  parameter int NF = N_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          wr_i,
  input  logic [DW-1:0] wdata_i,
  input  logic          op_vld_i,
  input  logic [NF-1:0] op_flags_i,
  output logic [NF-1:0] flags_o
);
  logic [NF-1:0] flags_q;
  logic [NF-1:0] flags_d;
  logic          direct_wr;

  // permission bit lives only for the write carrying it
  assign direct_wr = wr_i & wdata_i[FWE_BIT];

  for (genvar i = 0; i < NF; i++) begin : g_flag
    always_comb begin
      if (direct_wr)     flags_d[i] = wdata_i[i];
      else if (op_vld_i) flags_d[i] = flags_q[i] | op_flags_i[i];
      else               flags_d[i] = flags_q[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flags_q <= '0;
    else         flags_q <= flags_d;
  end

  logic unused_wbits;
  assign unused_wbits = ^wdata_i[FWE_BIT-1:NF];

  assign flags_o = flags_q;
endmodule

// File: rtl/fp_csr_trap.sv
module fp_csr_trap
  import fp_csr_pkg::*;
#(
  parameter int NF = N_FLAGS
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic          op_vld_i,
  input  logic [NF-1:0] op_flags_i,
  input  logic          iv_en_i,
  input  logic          dz_en_i,
  output logic          trap_o
);
  logic hit;
  logic trap_q;

  assign hit = op_vld_i & ((op_flags_i[FLG_IV] & iv_en_i) | (op_flags_i[FLG_DZ] & dz_en_i));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) trap_q <= 1'b0;
    else         trap_q <= hit;
  end

  logic unused_flags;
  assign unused_flags = ^op_flags_i[NF-1:FLG_DZ+1];

  assign trap_o = trap_q;
endmodule

// File: rtl/fp_csr_rdmux.sv
module fp_csr_rdmux
  import fp_csr_pkg::*;
#(
  parameter int DW = AUX_DW,
  parameter int NF = N_FLAGS
) (
  input  logic          re_i,
  input  logic          sel_ctrl_i,
  input  logic          sel_stat_i,
  input  ctrl_t         ctrl_i,
  input  logic [NF-1:0] flags_i,
  output logic [DW-1:0] rdata_o
);
  logic [DW-1:0] ctrl_img;
  logic [DW-1:0] stat_img;

  always_comb begin
    ctrl_img                = '0;
    ctrl_img[IV_EN_BIT]     = ctrl_i.iv_en;
    ctrl_img[DZ_EN_BIT]     = ctrl_i.dz_en;
    ctrl_img[RND_LSB+:2]    = ctrl_i.rnd;
    stat_img                = '0;
    stat_img[NF-1:0]        = flags_i;
  end

  always_comb begin
    rdata_o = '0;
    if (re_i && sel_ctrl_i)      rdata_o = ctrl_img;
    else if (re_i && sel_stat_i) rdata_o = stat_img;
  end
endmodule

// File: rtl/fp_csr.sv
module fp_csr
  import fp_csr_pkg::*;
#(
  parameter int                AW     = AUX_AW,
  parameter int                DW     = AUX_DW,
  parameter int                NF     = N_FLAGS,
  parameter logic [AW-1:0]     A_CTRL = CTRL_ADDR,
  parameter logic [AW-1:0]     A_STAT = STAT_ADDR
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  input  logic [AW-1:0] aux_addr_i,
  input  logic [DW-1:0] aux_wdata_i,
  input  logic          aux_we_i,
  input  logic          aux_re_i,
  output logic [DW-1:0] aux_rdata_o,
  input  logic          op_vld_i,
  input  logic [NF-1:0] op_flags_i,
  output logic [1:0]    rnd_mode_o,
  output logic          inv_en_o,
  output logic          dz_en_o,
  output logic          trap_req_o
);
  logic          sel_ctrl;
  logic          sel_stat;
  ctrl_t         ctrl_q;
  logic [NF-1:0] flags_q;

  assign sel_ctrl = (aux_addr_i == A_CTRL);
  assign sel_stat = (aux_addr_i == A_STAT);

  fp_csr_ctrl #(.DW(DW)) u_ctrl (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .wr_i    (aux_we_i & sel_ctrl),
    .wdata_i (aux_wdata_i),
    .ctrl_o  (ctrl_q)
  );

  fp_csr_flags #(.DW(DW), .NF(NF)) u_flags (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .wr_i       (aux_we_i & sel_stat),
    .wdata_i    (aux_wdata_i),
    .op_vld_i   (op_vld_i),
    .op_flags_i (op_flags_i),
    .flags_o    (flags_q)
  );

  fp_csr_trap #(.NF(NF)) u_trap (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .op_vld_i   (op_vld_i),
    .op_flags_i (op_flags_i),
    .iv_en_i    (ctrl_q.iv_en),
    .dz_en_i    (ctrl_q.dz_en),
    .trap_o     (trap_req_o)
  );

  fp_csr_rdmux #(.DW(DW), .NF(NF)) u_rdmux (
    .re_i       (aux_re_i),
    .sel_ctrl_i (sel_ctrl),
    .sel_stat_i (sel_stat),
    .ctrl_i     (ctrl_q),
    .flags_i    (flags_q),
    .rdata_o    (aux_rdata_o)
  );

  assign rnd_mode_o = ctrl_q.rnd;
  assign inv_en_o   = ctrl_q.iv_en;
  assign dz_en_o    = ctrl_q.dz_en;
endmodule

// File: rtl/fp_csr_chk.sv
module fp_csr_chk
  import fp_csr_pkg::*;
#(
  parameter int            AW     = AUX_AW,
  parameter int            DW     = AUX_DW,
  parameter int            NF     = N_FLAGS,
  parameter logic [AW-1:0] A_CTRL = CTRL_ADDR,
  parameter logic [AW-1:0] A_STAT = STAT_ADDR
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [AW-1:0] aux_addr_i,
  input logic [DW-1:0] aux_wdata_i,
  input logic          aux_we_i,
  input logic          aux_re_i,
  input logic [DW-1:0] aux_rdata_o,
  input logic          op_vld_i,
  input logic [NF-1:0] op_flags_i,
  input logic [1:0]    rnd_mode_o,
  input logic          inv_en_o,
  input logic          dz_en_o,
  input logic          trap_req_o,
  input logic [NF-1:0] flags_q
);
  logic st_wr, ct_wr;
  assign st_wr = aux_we_i && (aux_addr_i == A_STAT);
  assign ct_wr = aux_we_i && (aux_addr_i == A_CTRL);

  AST_FWE_LOAD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr && aux_wdata_i[FWE_BIT] |=> flags_q == $past(aux_wdata_i[NF-1:0])); // R8

  AST_NO_FWE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    st_wr && !aux_wdata_i[FWE_BIT] && !op_vld_i |=> $stable(flags_q)); // R5

  AST_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_vld_i && !(st_wr && aux_wdata_i[FWE_BIT])
    |=> (flags_q & ($past(flags_q) | $past(op_flags_i))) == ($past(flags_q) | $past(op_flags_i))); // R7

  AST_IDLE_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_vld_i && !st_wr |=> $stable(flags_q)); // R7

  AST_TRAP_RAISE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    op_vld_i && ((op_flags_i[FLG_IV] && inv_en_o) || (op_flags_i[FLG_DZ] && dz_en_o)) |=> trap_req_o); // R9

  AST_TRAP_CAUSE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !op_vld_i |=> !trap_req_o); // R9

  AST_CTRL_HOLD: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !ct_wr |=> $stable({rnd_mode_o, dz_en_o, inv_en_o})); // R3

  AST_RD_IDLE: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !aux_re_i |-> aux_rdata_o == '0); // R10

  AST_FWE_RAZ: assert property (@(posedge clk_i) disable iff (!rst_ni)
    aux_re_i && (aux_addr_i == A_STAT) |-> aux_rdata_o[DW-1:NF] == '0); // R6

  logic unused_bits;
  assign unused_bits = ^{aux_wdata_i[DW-1:FWE_BIT+1], aux_wdata_i[FWE_BIT-1:NF]};
endmodule

bind fp_csr fp_csr_chk #(
  .AW(AW), .DW(DW), .NF(NF), .A_CTRL(A_CTRL), .A_STAT(A_STAT)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .aux_addr_i  (aux_addr_i),
  .aux_wdata_i (aux_wdata_i),
  .aux_we_i    (aux_we_i),
  .aux_re_i    (aux_re_i),
  .aux_rdata_o (aux_rdata_o),
  .op_vld_i    (op_vld_i),
  .op_flags_i  (op_flags_i),
  .rnd_mode_o  (rnd_mode_o),
  .inv_en_o    (inv_en_o),
  .dz_en_o     (dz_en_o),
  .trap_req_o  (trap_req_o),
  .flags_q     (flags_q)
);

// File: tb/fp_csr_bench.sv
module fp_csr_bench;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [11:0] addr = '0;
  logic [31:0] wdata = '0;
  logic        we = 1'b0, re = 1'b0, vld = 1'b0;
  logic [4:0]  flg = '0;
  logic [31:0] rdata;
  logic [1:0]  rnd;
  logic        inv_en, dz_en, trap;

  int n_vec = 0, n_bad = 0;
  bit done = 0;

  always #(CLK_P/2) clk = ~clk;

  fp_csr u_fp_csr (
    .clk_i(clk), .rst_ni(rst_n), .aux_addr_i(addr), .aux_wdata_i(wdata),
    .aux_we_i(we), .aux_re_i(re), .aux_rdata_o(rdata), .op_vld_i(vld),
    .op_flags_i(flg), .rnd_mode_o(rnd), .inv_en_o(inv_en), .dz_en_o(dz_en),
    .trap_req_o(trap)
  );

  // behavioural reference
  int unsigned m_ctrl, m_stat;
  bit m_trap;
  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_ctrl = 32'h100; m_stat = 0; m_trap = 0;
    end else begin
      m_trap = vld && ((flg[0] && m_ctrl[0]) || (flg[1] && m_ctrl[1]));
      if (we && addr == 12'h301 && wdata[31]) m_stat = wdata & 32'h1F;
      else if (vld)                           m_stat = m_stat | 32'(flg);
      if (we && addr == 12'h300) m_ctrl = wdata & 32'h303;
    end
  end

  task automatic chk(input string tag, input string what, input logic [31:0] act, input logic [31:0] exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h at %0t", tag, what, act, exp, $time);
    end
  endtask

  task automatic cyc(input string tag, input logic [11:0] a, input logic [31:0] d,
                     input logic w, input logic r, input logic v, input logic [4:0] f);
    logic [31:0] exp_rd;
    @(negedge clk);
    addr = a; wdata = d; we = w; re = r; vld = v; flg = f;
    #1;
    exp_rd = !r ? 32'h0 : (a == 12'h300) ? m_ctrl : (a == 12'h301) ? m_stat : 32'h0;
    chk(tag, "rdata", rdata, exp_rd);
    chk(tag, "rnd", 32'(rnd), m_ctrl[9:8]);
    chk(tag, "inv_en", 32'(inv_en), 32'(m_ctrl[0]));
    chk(tag, "dz_en", 32'(dz_en), 32'(m_ctrl[1]));
    chk(tag, "trap", 32'(trap), 32'(m_trap));
  endtask

  task automatic rd(input string tag, input logic [11:0] a);
    cyc(tag, a, 32'h0, 1'b0, 1'b1, 1'b0, 5'h0);
  endtask

  task automatic wr(input string tag, input logic [11:0] a, input logic [31:0] d);
    cyc(tag, a, d, 1'b1, 1'b0, 1'b0, 5'h0);
  endtask

  task automatic op(input string tag, input logic [4:0] f);
    cyc(tag, 12'h0, 32'h0, 1'b0, 1'b0, 1'b1, f);
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    rd("R1", 12'h300);
    rd("R1", 12'h301);
    @(negedge clk); rst_n = 1'b1;
    rd("R1", 12'h300);
    rd("R1", 12'h301);
    // R2 unimplemented control bits
    wr("R2", 12'h300, 32'hFFFF_FFFF);
    rd("R2", 12'h300);
    wr("R2", 12'h300, 32'hFFFF_FCFC);
    rd("R2", 12'h300);
    // R3 every rounding code
    for (int m = 0; m < 4; m++) begin
      wr("R3", 12'h300, 32'(m) << 8 | 32'(m & 1));
      rd("R3", 12'h300);
    end
    // R5 status write without permission
    wr("R5", 12'h301, 32'h0000_001F);
    rd("R5", 12'h301);
    // R4 / R6 permitted write, then clear
    wr("R4", 12'h301, 32'hFFFF_FFF5);
    rd("R6", 12'h301);
    wr("R4", 12'h301, 32'h8000_000A);
    rd("R4", 12'h301);
    wr("R5", 12'h301, 32'h7FFF_FFE0);
    rd("R5", 12'h301);
    wr("R4", 12'h301, 32'h8000_0000);
    rd("R4", 12'h301);
    // R7 sticky accumulation, ignored when not valid
    op("R7", 5'b00001);
    op("R7", 5'b10000);
    rd("R7", 12'h301);
    cyc("R7", 12'h0, 32'h0, 1'b0, 1'b0, 1'b0, 5'b01110);
    rd("R7", 12'h301);
    op("R7", 5'b00000);
    rd("R7", 12'h301);
    // R8 direct write beats same-cycle report
    cyc("R8", 12'h301, 32'h8000_0002, 1'b1, 1'b0, 1'b1, 5'b11101);
    rd("R8", 12'h301);
    cyc("R8", 12'h301, 32'h0000_0000, 1'b1, 1'b0, 1'b1, 5'b00100);
    rd("R8", 12'h301);
    // R9 traps
    wr("R9", 12'h300, 32'h0000_0100);
    op("R9", 5'b00011);
    rd("R9", 12'h301);
    wr("R9", 12'h300, 32'h0000_0101);
    op("R9", 5'b00010);
    op("R9", 5'b00001);
    rd("R9", 12'h301);
    rd("R9", 12'h301);
    wr("R9", 12'h300, 32'h0000_0102);
    op("R9", 5'b00010);
    op("R9", 5'b00010);
    rd("R9", 12'h301);
    // enables change in the trap cycle: old enables decide
    cyc("R9", 12'h300, 32'h0000_0100, 1'b1, 1'b0, 1'b1, 5'b00010);
    op("R9", 5'b00010);
    rd("R9", 12'h301);
    // R10 other addresses and idle read strobe
    rd("R10", 12'h302);
    rd("R10", 12'h2FF);
    rd("R10", 12'h000);
    cyc("R10", 12'h301, 32'h0, 1'b0, 1'b0, 1'b0, 5'h0);
    // mixed random traffic
    for (int i = 0; i < 600; i++) begin
      logic [11:0] a;
      logic [31:0] d;
      case ($urandom % 4)
        0: a = 12'h300;
        1: a = 12'h301;
        2: a = 12'h301;
        default: a = 12'h2FF + 12'($urandom % 4);
      endcase
      d = $urandom;
      cyc("R7", a, d, ($urandom % 3) == 0, ($urandom % 2) == 0, ($urandom % 2) == 0, 5'($urandom));
    end
    rd("R7", 12'h301);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule